// File: doc/BRIEF.md
# Ping-Pong Line Time Compressor

This block stores one video component line by line in a pair of line buffers that swap roles at every line start. While the current line's active segment is written into one buffer at the sampling cadence, the buffer filled on the previous line is read back. In squeeze mode the read cadence is four thirds of the write cadence, so the stored segment leaves the block in three quarters of the time it took to arrive and is compressed horizontally. In pass-through mode the read cadence equals the write cadence: the picture keeps its width but is still delayed by one line.

A single line-locked master clock runs the whole block, which is four times the sampling rate. A write slot opens on every fourth master cycle. A read slot opens on every third cycle when squeezing, or on every fourth cycle when passing through. The read burst starts at a programmable number of master cycles after the line-start strobe, which is how a left, centre or right placement is chosen. The read-valid flag marks each sample that is delivered.

The writer FSM has the states WR_IDLE, WR_FILL and WR_DONE. A line start moves it from any state to WR_FILL. WR_FILL moves to WR_DONE on the last write. The reader FSM has the states RD_IDLE, RD_WAIT, RD_DRAIN and RD_DONE. At a line start it moves to RD_WAIT if the writer was in WR_DONE, and otherwise to RD_IDLE. RD_WAIT moves to RD_DRAIN when the delay count equals the latched offset. RD_DRAIN moves to RD_DONE on the last read. A line start takes priority over every other transition.

Top module: `line_squeeze_pp`

## Requirements
- R1: After reset, rd_valid_o and rd_data_o are 0. No read is delivered before the first line start, or during the first line after reset.
- R2: The samples read during a line are the samples written during the previous line, in the same order. Read k returns write k.
- R3: Call the clock edge that samples line_start_i high edge 0. Write k (k = 0 .. ACTIVE_SAMPLES-1) captures sample_i at edge 1+4k. After ACTIVE_SAMPLES writes, no further write occurs in that line.
- R4: With squeeze_i = 1 latched at the line start, read k is presented after edge offset+2+3k. rd_valid_o is high for exactly that one cycle.
- R5: With squeeze_i = 0 latched at the line start, read k is presented after edge offset+2+4k.
- R6: A line delivers at most ACTIVE_SAMPLES reads, and after that no rd_valid_o pulse until the next line start.
- R7: squeeze_i and rd_offset_i are sampled only on the line-start edge. Changing them later in the line has no effect on the read timing.
- R8: Reads happen in a line only if the previous line completed all ACTIVE_SAMPLES writes before the line start.
- R9: The buffer select toggles on every line start and holds otherwise. A line is written into one buffer while the other buffer is read, so reading never corrupts the data being stored.
- R10: A line start aborts any read in progress. No read is delivered in the cycle after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four times the sampling rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start_i | input | 1 | One-cycle line-start strobe |
| squeeze_i | input | 1 | 1 = squeeze (read every 3rd cycle), 0 = pass-through (every 4th) |
| rd_offset_i | input | OFS_W | Read start delay in master cycles after line start |
| sample_i | input | DATA_W | Incoming sample |
| rd_valid_o | output | 1 | One-cycle pulse per delivered sample |
| rd_data_o | output | DATA_W | Delivered sample |

## Verification
On every cycle the checker confirms the following:
- Two valid pulses are never adjacent.
- No pulse follows a strobe edge directly, and none appears before the first line start.
- The per-line write and read counts never exceed the segment length.
- The buffer select flips exactly on strobes.

Only the bench scenarios can show the rest: that data order and the one-line delay are preserved, that reads land on the exact 3-cycle or 4-cycle grid after the offset, that mid-line changes to mode and offset are ignored, and that a short line suppresses the reads of the following line.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_FILL,
        WR_DONE
    } wr_state_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_WAIT,
        RD_DRAIN,
        RD_DONE
    } rd_state_t;

endpackage

// File: rtl/lsq_pace_tick.sv
module lsq_pace_tick #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == (div - PW'(1))) ? '0 : cnt + PW'(1);
        end
    end

    assign tick = run && (cnt == '0);
endmodule

// File: rtl/lsq_write_fsm.sv
module lsq_write_fsm
    import lsq_pkg::*;
#(
    parameter int N  = 662,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          tick,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          pace_run,
    output logic          complete
);
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    wr_state_t     state, nxt;
    logic [AW-1:0] ptr;

    always_comb begin
        nxt = state;
        unique case (state)
            WR_IDLE: nxt = WR_IDLE;
            WR_FILL: nxt = (wr_en && ptr == LAST) ? WR_DONE : WR_FILL;
            WR_DONE: nxt = WR_DONE;
            default: nxt = WR_IDLE;
        endcase
        if (line_start) nxt = WR_FILL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WR_IDLE;
            ptr   <= '0;
        end else begin
            state <= nxt;
            if (line_start)  ptr <= '0;
            else if (wr_en)  ptr <= ptr + AW'(1);
        end
    end

    always_comb begin
        pace_run = (state == WR_FILL);
        wr_en    = pace_run && tick && !line_start;
        complete = (state == WR_DONE);
        wr_addr  = ptr;
    end
endmodule

// File: rtl/lsq_read_fsm.sv
module lsq_read_fsm
    import lsq_pkg::*;
#(
    parameter int N  = 662,
    parameter int AW = 10,
    parameter int OW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          prev_done,
    input  logic [OW-1:0] ofs_q,
    input  logic          tick,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          pace_run,
    output logic          pace_restart
);
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    rd_state_t     state, nxt;
    logic [OW-1:0] dly;
    logic [AW-1:0] ptr;
    logic          hit;

    assign hit = (dly == ofs_q);

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:  nxt = RD_IDLE;
            RD_WAIT:  nxt = hit ? RD_DRAIN : RD_WAIT;
            RD_DRAIN: nxt = (rd_en && ptr == LAST) ? RD_DONE : RD_DRAIN;
            RD_DONE:  nxt = RD_DONE;
            default:  nxt = RD_IDLE;
        endcase
        if (line_start) nxt = prev_done ? RD_WAIT : RD_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_IDLE;
            dly   <= '0;
            ptr   <= '0;
        end else begin
            state <= nxt;
            if (line_start)                   dly <= '0;
            else if (state == RD_WAIT && !hit) dly <= dly + OW'(1);
            if (line_start)                   ptr <= '0;
            else if (rd_en)                   ptr <= ptr + AW'(1);
        end
    end

    always_comb begin
        pace_run     = (state == RD_DRAIN);
        rd_en        = pace_run && tick && !line_start;
        pace_restart = line_start || (state == RD_WAIT && hit);
        rd_addr      = ptr;
    end
endmodule

// File: rtl/lsq_bank_pair.sv
module lsq_bank_pair #(
    parameter int DW = 10,
    parameter int N  = 662,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          wsel,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic          rsel,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] word_g [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [DW-1:0] mem [N];
        always_ff @(posedge clk) begin
            if (we && (wsel == 1'(g))) mem[waddr] <= wdata;
        end
        assign word_g[g] = mem[raddr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= word_g[rsel];
    end
endmodule

// File: rtl/line_squeeze_pp.sv
module line_squeeze_pp
    import lsq_pkg::*;
#(
    parameter int DATA_W         = 10,
    parameter int ACTIVE_SAMPLES = 662,
    parameter int OFS_W          = 12,
    parameter int WR_DIV         = 4,
    parameter int RD_DIV_SQZ     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_i,
    input  logic              squeeze_i,
    input  logic [OFS_W-1:0]  rd_offset_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int AW = $clog2(ACTIVE_SAMPLES);
    localparam int PW = $clog2(WR_DIV + 1);
    localparam logic [PW-1:0] DIV_WR  = PW'(WR_DIV);
    localparam logic [PW-1:0] DIV_SQZ = PW'(RD_DIV_SQZ);

    logic             bank_sel;
    logic [PW-1:0]    rd_div_q;
    logic [OFS_W-1:0] ofs_q;

    logic          wr_tick, wr_run, wr_en, wr_complete;
    logic [AW-1:0] wr_addr;
    logic          rd_tick, rd_run, rd_restart, rd_en;
    logic [AW-1:0] rd_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_sel   <= 1'b0;
            rd_div_q   <= DIV_WR;
            ofs_q      <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            if (line_start_i) begin
                bank_sel <= ~bank_sel;
                rd_div_q <= squeeze_i ? DIV_SQZ : DIV_WR;
                ofs_q    <= rd_offset_i;
            end
            rd_valid_o <= rd_en;
        end
    end

    lsq_pace_tick #(.PW(PW)) u_wr_pace (
        .clk(clk), .rst_n(rst_n), .restart(line_start_i),
        .run(wr_run), .div(DIV_WR), .tick(wr_tick)
    );

    lsq_pace_tick #(.PW(PW)) u_rd_pace (
        .clk(clk), .rst_n(rst_n), .restart(rd_restart),
        .run(rd_run), .div(rd_div_q), .tick(rd_tick)
    );

    lsq_write_fsm #(.N(ACTIVE_SAMPLES), .AW(AW)) u_wr (
        .clk(clk), .rst_n(rst_n), .line_start(line_start_i), .tick(wr_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .pace_run(wr_run),
        .complete(wr_complete)
    );

    lsq_read_fsm #(.N(ACTIVE_SAMPLES), .AW(AW), .OW(OFS_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .line_start(line_start_i),
        .prev_done(wr_complete), .ofs_q(ofs_q), .tick(rd_tick),
        .rd_en(rd_en), .rd_addr(rd_addr), .pace_run(rd_run),
        .pace_restart(rd_restart)
    );

    lsq_bank_pair #(.DW(DATA_W), .N(ACTIVE_SAMPLES), .AW(AW)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .wsel(bank_sel), .waddr(wr_addr), .wdata(sample_i),
        .re(rd_en), .rsel(~bank_sel), .raddr(rd_addr), .rdata(rd_data_o)
    );
endmodule

// File: rtl/lsq_checker.sv
module lsq_checker #(
    parameter int N = 662
) (
    input logic clk,
    input logic rst_n,
    input logic line_start,
    input logic rd_valid,
    input logic wr_en,
    input logic bank_sel
);
    localparam int CW = $clog2(N + 2) + 1;

    logic [CW-1:0] wr_cnt, rd_cnt;
    logic          seen_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt     <= '0;
            rd_cnt     <= '0;
            seen_start <= 1'b0;
        end else begin
            if (line_start) seen_start <= 1'b1;
            if (line_start)                wr_cnt <= '0;
            else if (wr_en && wr_cnt != '1) wr_cnt <= wr_cnt + CW'(1);
            if (line_start)                   rd_cnt <= '0;
            else if (rd_valid && rd_cnt != '1) rd_cnt <= rd_cnt + CW'(1);
        end
    end

    p_idle_before_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start |-> !rd_valid);
    p_wr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= CW'(N));
    p_read_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    p_rd_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= CW'(N));
    p_bank_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (bank_sel != $past(bank_sel)));
    p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(bank_sel));
    p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !rd_valid);
endmodule

bind line_squeeze_pp lsq_checker #(.N(ACTIVE_SAMPLES)) u_lsq_chk (
    .clk(clk),
    .rst_n(rst_n),
    .line_start(line_start_i),
    .rd_valid(rd_valid_o),
    .wr_en(wr_en),
    .bank_sel(bank_sel)
);

// File: tb/line_squeeze_pp_tb_top.sv
module line_squeeze_pp_tb_top;
    localparam int DW   = 12;
    localparam int N    = 20;
    localparam int OW   = 6;
    localparam int MAXL = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_start_i = 1'b0;
    logic          squeeze_i = 1'b0;
    logic [OW-1:0] rd_offset_i = '0;
    logic [DW-1:0] sample_i = '0;
    logic          rd_valid_o;
    logic [DW-1:0] rd_data_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    logic [DW-1:0] cur_s  [MAXL];
    logic [DW-1:0] prev_s [MAXL];
    bit            prev_complete = 1'b0;

    always #2 clk = ~clk;

    line_squeeze_pp #(
        .DATA_W(DW), .ACTIVE_SAMPLES(N), .OFS_W(OW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
        .squeeze_i(squeeze_i), .rd_offset_i(rd_offset_i),
        .sample_i(sample_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int read_edge(input int ofs, input int div, input int k);
        return ofs + 2 + div * k;
    endfunction

    function automatic int write_edge(input int k);
        return 1 + 4 * k;
    endfunction

    function automatic int expected_reads(input bit full, input int len, input int ofs, input int div);
        int n;
        if (!full || (len - 1) < ofs + 2) return 0;
        n = (len - 3 - ofs) / div + 1;
        return (n > N) ? N : n;
    endfunction

    task automatic run_line(input int len, input bit sqz, input int ofs);
        int div;
        int rcnt;
        int exp_t;
        div  = sqz ? 3 : 4;
        rcnt = 0;
        line_start_i = 1'b1;
        squeeze_i    = sqz;
        rd_offset_i  = OW'(ofs);
        sample_i     = DW'($urandom);
        cur_s[0]     = sample_i;
        for (int i = 0; i < len; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 0) begin
                chk(!rd_valid_o, "R10", int'(rd_valid_o), 0);
            end else if (rd_valid_o) begin
                if (!prev_complete || rcnt >= N) begin
                    chk(1'b0, "R8", rcnt + 1, prev_complete ? N : 0);
                end else begin
                    exp_t = read_edge(ofs, div, rcnt);
                    chk(i == exp_t, sqz ? "R4" : "R5", i, exp_t);
                    chk(rd_data_o == prev_s[write_edge(rcnt)], "R2",
                        int'(rd_data_o), int'(prev_s[write_edge(rcnt)]));
                end
                rcnt++;
            end
            // R7: mode and offset scrambled after the strobe edge
            line_start_i = 1'b0;
            squeeze_i    = 1'($urandom);
            rd_offset_i  = OW'($urandom);
            sample_i     = DW'($urandom);
            if (i + 1 < MAXL) cur_s[i + 1] = sample_i;
        end
        chk(rcnt == expected_reads(prev_complete, len, ofs, div), "R6",
            rcnt, expected_reads(prev_complete, len, ofs, div));
        // R3: the line is complete only if write N-1 fits before the next strobe
        prev_complete = (len >= 4 * N - 2);
        for (int j = 0; j < MAXL; j++) prev_s[j] = cur_s[j];
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(!rd_valid_o && rd_data_o == '0, "R1", int'(rd_data_o) + int'(rd_valid_o), 0);
        end
        run_line(90, 1'b1, 5);     // R1: first line after reset delivers nothing
        run_line(100, 1'b1, 0);    // R4: zero offset, squeeze
        run_line(120, 1'b0, 10);   // R5: pass-through
        run_line(150, 1'b0, 63);   // R5: largest offset
        run_line(100, 1'b1, 20);   // R2 R9: back-to-back lines keep data apart
        run_line(40, 1'b1, 3);     // R10: early strobe truncates reads, line incomplete
        run_line(100, 1'b1, 2);    // R8: previous short line gives no reads
        run_line(100, 1'b0, 1);    // R3: full data after recovery
        run_line(77, 1'b1, 0);     // R8: one cycle short of complete
        run_line(90, 1'b1, 0);
        run_line(78, 1'b1, 4);     // R3: exactly long enough
        run_line(90, 1'b0, 0);
        for (int n = 0; n < 24; n++) begin
            run_line(70 + int'($urandom % 80), 1'($urandom), int'($urandom % 64));
        end
        @(negedge clk);
        line_start_i = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule